// File: doc/BRIEF.md
# Rate-Half Constraint-Length-7 Convolutional Encoder

This block is a serial channel coder for a hard-decision Viterbi receiver path. Each cycle in which the upstream side raises `in_valid`, the block takes one data bit. One clock later it presents a two-bit code symbol on `out_sym`, with `out_valid` high. The coded stream is formed from the current bit and the six bits accepted before it. Together these give a 64-state code, with generator taps 171 and 133 in octal. The same block also produces reference code words for a decoder under test.

The encoder has no framing of its own. To terminate a message, the user appends six zero bits. After those bits the memory is back in the all-zero state, so the next message starts from a known trellis root. A synchronous, active-high reset also returns the memory to that state.

Top module: `conv_enc_k7`

## Requirements
- R1: The cycle after `rst` is sampled high, `out_valid` is 0, `out_sym` is 2'b00 and the six-bit history is all zero.
- R2: When `in_valid` is high at a rising edge, `out_valid` is high in the following cycle and carries the symbol for that bit.
- R3: When `in_valid` is low at a rising edge, the following cycle has `out_valid` low and `out_sym` unchanged, and the history does not move. The symbols produced after an idle gap equal those of the same bits sent without the gap.
- R4: `out_sym[1]` is the XOR of the bits of {in_bit, h1..h6} selected by 7'o171, where bit 6 of the mask selects `in_bit` and h1 is the most recently accepted bit.
- R5: `out_sym[0]` is the XOR of the same seven-bit vector masked with 7'o133.
- R6: From the all-zero history, a single 1 followed by zeros yields the symbols 11, 10, 11, 11, 00, 01, 11, and then 00.
- R7: After any message followed by six accepted zero bits, a further zero yields 2'b00 and a further one yields 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data bit present this cycle |
| in_bit | input | 1 | Data bit to encode |
| out_valid | output | 1 | Code symbol present, one cycle after acceptance |
| out_sym | output | 2 | Code symbol: bit 1 from generator 171, bit 0 from generator 133 |

## Verification
The bench builds the block with its default parameters: constraint length 7 and the 171/133 generator pair. With these, every one of the 64 history states and both input values can be reached by a random bit stream of a few thousand bits. Idle gaps are inserted at random, so that held history and out-of-step symbol timing are exercised under the real code. Directed impulse and zero-tail sequences pin down the tap order, because a reversed or shifted tap set changes the impulse response.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
  // Code symbol width for a rate-half code.
  localparam int unsigned SYM_W = 2;

  // Default constraint length and generator masks (octal).
  localparam int unsigned DEF_CL = 7;
  localparam logic [DEF_CL-1:0] DEF_GEN_A = 7'o171;
  localparam logic [DEF_CL-1:0] DEF_GEN_B = 7'o133;

  typedef logic [SYM_W-1:0] code_sym_t;
endpackage

// File: rtl/conv_enc_history.sv
module conv_enc_history #(
  parameter int unsigned MEM = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           bit_in,
  output logic [MEM-1:0] hist
);
  // hist[MEM-1] is the most recently accepted bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
    end else if (shift_en) begin
      hist <= {bit_in, hist[MEM-1:1]};
    end
  end

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist)); // R3

  AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist[MEM-1] == $past(bit_in)); // R4

  AST_HIST_AGE: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist[MEM-2:0] == $past(hist[MEM-1:1])); // R4
endmodule

// File: rtl/conv_enc_parity.sv
module conv_enc_parity #(
  parameter int unsigned            WIDTH = 7,
  parameter int unsigned            NOUT  = 2,
  parameter logic [NOUT*WIDTH-1:0]  GENS  = {7'o171, 7'o133}
) (
  input  logic [WIDTH-1:0] vec,
  output logic [NOUT-1:0]  par
);
  // The first generator in GENS drives the highest output bit.
  for (genvar g = 0; g < NOUT; g++) begin : g_tap
    localparam int unsigned HI = (NOUT - g) * WIDTH - 1;
    assign par[NOUT-1-g] = ^(vec & GENS[HI -: WIDTH]);
  end
endmodule

// File: rtl/conv_enc_k7.sv
module conv_enc_k7
  import conv_enc_pkg::*;
#(
  parameter int unsigned        CL    = DEF_CL,
  parameter logic [CL-1:0]      GEN_A = DEF_GEN_A,
  parameter logic [CL-1:0]      GEN_B = DEF_GEN_B
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       out_valid,
  output logic [1:0] out_sym
);
  localparam int unsigned MEM = CL - 1;

  logic [MEM-1:0] hist;
  code_sym_t      sym_next;

  conv_enc_history #(.MEM(MEM)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (in_valid),
    .bit_in   (in_bit),
    .hist     (hist)
  );

  conv_enc_parity #(
    .WIDTH (CL),
    .NOUT  (SYM_W),
    .GENS  ({GEN_A, GEN_B})
  ) u_par (
    .vec (({in_bit, hist})),
    .par (sym_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sym   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sym <= sym_next;
    end
  end

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(out_sym)); // R3

  AST_IMPULSE_HEAD: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_bit && hist == '0 |=> out_sym == 2'b11); // R6

  AST_ZERO_ROOT: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_bit && hist == '0 |=> out_sym == 2'b00); // R7
endmodule

// File: tb/conv_enc_k7_test.sv
`timescale 1ns/1ps
module conv_enc_k7_test;
  logic clk = 1'b0;
  logic rst, in_valid, in_bit;
  logic out_valid;
  logic [1:0] out_sym;

  int n_run = 0;
  int n_fail = 0;
  logic [5:0] m_hist;
  logic       exp_v;
  logic [1:0] exp_s;
  logic       have_exp;

  always #2.5 clk = ~clk;

  conv_enc_k7 uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .out_valid(out_valid), .out_sym(out_sym)
  );

  function automatic logic [1:0] model_sym(input logic b, input logic [5:0] h);
    logic [6:0] v;
    v = {b, h};
    return {^(v & 7'o171), ^(v & 7'o133)};
  endfunction

  task automatic check(input string req, input logic v, input logic [1:0] s);
    n_run++;
    if (out_valid !== v || (v && out_sym !== s)) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b sym=%b, expected valid=%0b sym=%b",
               req, out_valid, out_sym, v, s);
    end
  endtask

  // Drive one cycle: check result of previous cycle, then apply new inputs.
  task automatic step(input string req, input logic v, input logic b);
    @(negedge clk);
    if (have_exp) check(req, exp_v, exp_s);
    in_valid = v;
    in_bit   = b;
    exp_v    = v;
    if (v) begin
      exp_s  = model_sym(b, m_hist);
      m_hist = {b, m_hist[5:1]};
    end
    have_exp = 1'b1;
  endtask

  task automatic flush(input string req);
    @(negedge clk);
    check(req, exp_v, exp_s);
    in_valid = 1'b0;
    exp_v    = 1'b0;
    have_exp = 1'b0;
  endtask

  task automatic expect_sym(input string req, input logic [1:0] s);
    @(negedge clk);
    n_run++;
    if (out_valid !== 1'b1 || out_sym !== s) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b sym=%b, expected valid=1 sym=%b",
               req, out_valid, out_sym, s);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] imp [7];
    logic [1:0] held;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0;
    m_hist = '0; exp_v = 1'b0; exp_s = 2'b00; have_exp = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_run++;
    if (out_valid !== 1'b0 || out_sym !== 2'b00) begin
      n_fail++;
      $display("FAIL R1: got valid=%0b sym=%b, expected valid=0 sym=00", out_valid, out_sym);
    end
    rst = 1'b0;

    // R6: impulse response from zero state
    imp[0] = 2'b11; imp[1] = 2'b10; imp[2] = 2'b11; imp[3] = 2'b11;
    imp[4] = 2'b00; imp[5] = 2'b01; imp[6] = 2'b11;
    @(negedge clk); in_valid = 1'b1; in_bit = 1'b1;
    for (int i = 0; i < 8; i++) begin
      expect_sym("R6", (i < 7) ? imp[i] : 2'b00);
      in_bit = 1'b0;
    end
    in_valid = 1'b0;
    m_hist = '0; have_exp = 1'b0;

    // R1: reset mid-stream clears history
    step("R4,R5", 1'b1, 1'b1);
    step("R4,R5", 1'b1, 1'b1);
    flush("R2");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    n_run++;
    if (out_valid !== 1'b0 || out_sym !== 2'b00) begin
      n_fail++;
      $display("FAIL R1: got valid=%0b sym=%b, expected valid=0 sym=00", out_valid, out_sym);
    end
    m_hist = '0;
    step("R1", 1'b1, 1'b0);
    step("R1", 1'b1, 1'b1);   // from zero history a 0 gives 00
    flush("R1");              // and then 1 after one 0 gives model value

    // R3: idle gap holds output and history
    step("R2", 1'b1, 1'b1);
    flush("R2");
    held = out_sym;
    repeat (4) @(negedge clk);
    n_run++;
    if (out_valid !== 1'b0 || out_sym !== held) begin
      n_fail++;
      $display("FAIL R3: got valid=%0b sym=%b, expected valid=0 sym=%b", out_valid, out_sym, held);
    end
    step("R3", 1'b1, 1'b0);
    step("R3", 1'b1, 1'b1);
    flush("R3");

    // R2, R3, R4, R5, R7: random messages with gaps and zero tails
    for (int msg = 0; msg < 40; msg++) begin
      int len = 20 + ($urandom % 80);
      for (int i = 0; i < len; i++) begin
        logic v = ($urandom % 4) != 0;
        step("R4,R5,R3", v, 1'($urandom));
      end
      for (int i = 0; i < 6; i++) step("R7", 1'b1, 1'b0);
      step("R7", 1'b1, 1'($urandom));
      // after the tail, symbol depends only on the new bit
      @(negedge clk);
      n_run++;
      if (out_valid !== 1'b1 || out_sym !== (in_bit ? 2'b11 : 2'b00)) begin
        n_fail++;
        $display("FAIL R7: got valid=%0b sym=%b, expected valid=1 sym=%b",
                 out_valid, out_sym, in_bit ? 2'b11 : 2'b00);
      end
      in_valid = 1'b0;
      exp_v = 1'b0;
      have_exp = 1'b0;
    end
    flush("R3");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule